// File: doc/BRIEF.md
# Error-Scheduled Dual-Gain DC Link Voltage Regulator

This block is the outer voltage loop of a boost power factor stage. On each control tick it takes the difference between the DC link reference and the DC link sample. It forms the size of that difference and turns it into a weight with a piecewise-linear membership. Below a lower breakpoint only a gentle proportional-integral gain pair is used, which keeps line-frequency ripple out of the command. Above an upper breakpoint only an aggressive pair is used, so that load steps recover quickly. Between the two breakpoints the pairs are mixed in proportion to the weight. This lets steady-state distortion and transient speed be tuned separately.

Both gain pairs drive a single integrator, which is clamped to programmable bounds. The regulator output is a non-negative current amplitude command, since the stage can only draw power from the mains. Every clock cycle the command is multiplied by the rectified mains sample to give the instantaneous current reference for the inner current loop. The reference register typically holds the code for a 405 V link.

Top module: `dclink_sched_pi`

## Requirements
- R1: While reset is asserted, and after its release until the first tick, `amp_cmd` and `iref` are 0 and the integrator is 0.
- R2: The error is e = `vdc_ref` − `vdc_meas`, as a signed value. The proportional-integral output is floor((Kp·e + A) / 2^8), where A is the integrator value after the current update.
- R3: When |e| ≤ `band_lo`, the weight is 0 and only `kp_lo`/`ki_lo` take effect.
- R4: When |e| ≥ `band_hi` (and |e| > `band_lo`), the weight is 32768 (1.0 in Q1.15) and only `kp_hi`/`ki_hi` take effect.
- R5: When |e| lies strictly between the breakpoints, the weight is min((|e| − `band_lo`)·`band_inv`, 32768). Each applied gain is floor((Klo·(32768 − w) + Khi·w) / 32768).
- R6: A single integrator serves both gain pairs. On each tick it becomes A + Ki·e, saturated to [`int_min`, `int_max`].
- R7: `amp_cmd` is the output of R2 clamped to the range 0..65535. Negative results give 0.
- R8: `amp_cmd` and the integrator change only on the clock edge where `tick` is high, and hold otherwise.
- R9: On every clock edge, `iref` takes floor(`amp_cmd`·`vac_mag` / 65536). A new amplitude therefore shows on `iref` one cycle after it appears on `amp_cmd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Control update strobe, one cycle wide |
| vdc_meas | input | 16 | DC link sample, unsigned code |
| vdc_ref | input | 16 | DC link target, unsigned code |
| vac_mag | input | 16 | Rectified mains sample, unsigned code |
| band_lo | input | 16 | Lower membership breakpoint on the error magnitude |
| band_hi | input | 16 | Upper membership breakpoint on the error magnitude |
| band_inv | input | 16 | Slope constant, 32768/(band_hi − band_lo) |
| kp_lo | input | 16 | Steady-state proportional gain, Q8.8 |
| ki_lo | input | 16 | Steady-state integral gain |
| kp_hi | input | 16 | Transient proportional gain, Q8.8 |
| ki_hi | input | 16 | Transient integral gain |
| int_min | input | 32 | Integrator lower bound, signed |
| int_max | input | 32 | Integrator upper bound, signed |
| amp_cmd | output | 16 | Current amplitude command |
| iref | output | 16 | Instantaneous current reference |

## Verification
The assertions assume that `int_min` ≤ `int_max` and that both bounds stay unchanged across a tick. They also assume that `band_inv` is consistent with the breakpoints, so that the weight never goes past 1.0 inside the band. The bench writes the configuration only while `tick` is low and keeps `band_lo` below `band_hi`. It picks a slope constant that divides exactly, and it changes the integrator bounds only between ticks. Under these conditions the weight, the blended gains and the integrator range all stay inside the limits that the properties check.

// File: rtl/dclink_pkg.sv
package dclink_pkg;
  // Fraction bits of the membership weight (Q1.15)
  localparam int WQ = 15;
  localparam logic [WQ:0] W_ONE = {1'b1, {WQ{1'b0}}};
endpackage

// File: rtl/dcl_weight.sv
module dcl_weight
  import dclink_pkg::*;
#(
  parameter int DW = 16,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW:0]   mag,
  input  logic [DW-1:0] m_lo,
  input  logic [DW-1:0] m_hi,
  input  logic [SW-1:0] slope,
  output logic [WQ:0]   w
);
  localparam int PW = DW + 1 + SW;

  function automatic logic [WQ:0] memb(input logic [DW:0] a, input logic [DW-1:0] lo,
                                       input logic [DW-1:0] hi, input logic [SW-1:0] s);
    logic [DW:0]   d;
    logic [PW-1:0] p;
    d = a - {1'b0, lo};
    p = {{SW{1'b0}}, d} * {{(DW+1){1'b0}}, s};
    if (a <= {1'b0, lo})                          return '0;
    else if (a >= {1'b0, hi})                     return W_ONE;
    else if (p > {{(PW-WQ-1){1'b0}}, W_ONE})      return W_ONE;
    else                                          return p[WQ:0];
  endfunction

  assign w = memb(mag, m_lo, m_hi, slope);

  a_r3_weight_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mag <= {1'b0, m_lo}) |-> (w == '0));
  a_r4_weight_full: assert property (@(posedge clk) disable iff (!rst_n)
    ((mag >= {1'b0, m_hi}) && (mag > {1'b0, m_lo})) |-> (w == W_ONE));
  a_r5_weight_range: assert property (@(posedge clk) disable iff (!rst_n)
    w <= W_ONE);
endmodule

// File: rtl/dcl_blend.sv
module dcl_blend
  import dclink_pkg::*;
#(
  parameter int GW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [GW-1:0] k_a,
  input  logic [GW-1:0] k_b,
  input  logic [WQ:0]   w,
  output logic [GW-1:0] k
);
  localparam int BW = GW + WQ;

  function automatic logic [GW-1:0] mix(input logic [GW-1:0] a, input logic [GW-1:0] b,
                                        input logic [WQ:0] wt);
    logic [WQ:0]   wc;
    logic [BW-1:0] t;
    wc = W_ONE - wt;
    t  = ({{WQ{1'b0}}, a} * {{(GW-1){1'b0}}, wc}) + ({{WQ{1'b0}}, b} * {{(GW-1){1'b0}}, wt});
    return t[BW-1:WQ];
  endfunction

  assign k = mix(k_a, k_b, w);

  // R5: a blended gain never leaves the span of its two endpoints
  a_r5_blend_span: assert property (@(posedge clk) disable iff (!rst_n)
    (w <= W_ONE) |-> (((k >= k_a) || (k >= k_b)) && ((k <= k_a) || (k <= k_b))));
endmodule

// File: rtl/dcl_pi_core.sv
module dcl_pi_core #(
  parameter int DW = 16,
  parameter int GW = 16,
  parameter int AW = 32,
  parameter int OW = 16,
  parameter int QS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic signed [DW:0]   e,
  input  logic [GW-1:0]        kp,
  input  logic [GW-1:0]        ki,
  input  logic signed [AW-1:0] lim_lo,
  input  logic signed [AW-1:0] lim_hi,
  output logic signed [AW-1:0] acc,
  output logic [OW-1:0]        amp
);
  localparam int PW = DW + GW + 2;
  localparam int SW = ((PW > AW) ? PW : AW) + 1;

  function automatic logic signed [PW-1:0] mul(input logic [GW-1:0] g, input logic signed [DW:0] x);
    logic signed [PW-1:0] a, b;
    a = $signed({{(DW+2){1'b0}}, g});
    b = $signed({{(GW+1){x[DW]}}, x});
    return a * b;
  endfunction

  function automatic logic signed [SW-1:0] xa(input logic signed [AW-1:0] v);
    return $signed({{(SW-AW){v[AW-1]}}, v});
  endfunction

  function automatic logic signed [SW-1:0] xp(input logic signed [PW-1:0] v);
    return $signed({{(SW-PW){v[PW-1]}}, v});
  endfunction

  function automatic logic signed [AW-1:0] integ(input logic signed [AW-1:0] a,
      input logic [GW-1:0] g, input logic signed [DW:0] x,
      input logic signed [AW-1:0] lo, input logic signed [AW-1:0] hi);
    logic signed [SW-1:0] s;
    s = xa(a) + xp(mul(g, x));
    if (s > xa(hi))      return hi;
    else if (s < xa(lo)) return lo;
    else                 return s[AW-1:0];
  endfunction

  function automatic logic [OW-1:0] outmap(input logic [GW-1:0] g, input logic signed [DW:0] x,
                                           input logic signed [AW-1:0] a);
    logic signed [SW-1:0] s, sh, top;
    s   = xp(mul(g, x)) + xa(a);
    sh  = s >>> QS;
    top = $signed({{(SW-OW){1'b0}}, {OW{1'b1}}});
    if (sh < 0)        return '0;
    else if (sh > top) return {OW{1'b1}};
    else               return sh[OW-1:0];
  endfunction

  logic signed [AW-1:0] acc_nx;
  assign acc_nx = integ(acc, ki, e, lim_lo, lim_hi);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
      amp <= '0;
    end else if (tick) begin
      acc <= acc_nx;
      amp <= outmap(kp, e, acc_nx);
    end
  end

  a_r8_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(acc) && $stable(amp)));
  a_r6_acc_in_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ((acc >= $past(lim_lo)) && (acc <= $past(lim_hi))));
endmodule

// File: rtl/dclink_sched_pi.sv
module dclink_sched_pi
  import dclink_pkg::*;
#(
  parameter int DW = 16,
  parameter int SW = 16,
  parameter int GW = 16,
  parameter int AW = 32,
  parameter int OW = 16,
  parameter int QS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic [DW-1:0]        vdc_meas,
  input  logic [DW-1:0]        vdc_ref,
  input  logic [DW-1:0]        vac_mag,
  input  logic [DW-1:0]        band_lo,
  input  logic [DW-1:0]        band_hi,
  input  logic [SW-1:0]        band_inv,
  input  logic [GW-1:0]        kp_lo,
  input  logic [GW-1:0]        ki_lo,
  input  logic [GW-1:0]        kp_hi,
  input  logic [GW-1:0]        ki_hi,
  input  logic signed [AW-1:0] int_min,
  input  logic signed [AW-1:0] int_max,
  output logic [OW-1:0]        amp_cmd,
  output logic [OW-1:0]        iref
);
  localparam int EW = DW + 1;
  localparam int NG = 2;   // gain index 0: proportional, 1: integral
  localparam int MW = OW + DW;

  logic signed [EW-1:0] err;
  logic [EW-1:0]        err_mag;
  logic [WQ:0]          wt;
  logic [GW-1:0]        g_lo [NG];
  logic [GW-1:0]        g_hi [NG];
  logic [GW-1:0]        g_mix [NG];
  logic signed [AW-1:0] integ_q;

  function automatic logic [EW-1:0] absval(input logic signed [EW-1:0] x);
    return x[EW-1] ? EW'(-x) : EW'(x);
  endfunction

  function automatic logic [OW-1:0] scale(input logic [OW-1:0] a, input logic [DW-1:0] v);
    logic [MW-1:0] p;
    p = {{DW{1'b0}}, a} * {{OW{1'b0}}, v};
    return p[MW-1:DW];
  endfunction

  assign err     = $signed({1'b0, vdc_ref}) - $signed({1'b0, vdc_meas});
  assign err_mag = absval(err);

  assign g_lo[0] = kp_lo;
  assign g_lo[1] = ki_lo;
  assign g_hi[0] = kp_hi;
  assign g_hi[1] = ki_hi;

  dcl_weight #(.DW(DW), .SW(SW)) u_weight (
    .clk(clk), .rst_n(rst_n), .mag(err_mag), .m_lo(band_lo), .m_hi(band_hi),
    .slope(band_inv), .w(wt)
  );

  for (genvar g = 0; g < NG; g++) begin : g_gain
    dcl_blend #(.GW(GW)) u_blend (
      .clk(clk), .rst_n(rst_n), .k_a(g_lo[g]), .k_b(g_hi[g]), .w(wt), .k(g_mix[g])
    );
  end

  dcl_pi_core #(.DW(DW), .GW(GW), .AW(AW), .OW(OW), .QS(QS)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .e(err), .kp(g_mix[0]), .ki(g_mix[1]),
    .lim_lo(int_min), .lim_hi(int_max), .acc(integ_q), .amp(amp_cmd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) iref <= '0;
    else        iref <= scale(amp_cmd, vac_mag);
  end

  a_r9_zero_amp_zero_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (amp_cmd == '0) |=> (iref == '0));
  a_r9_ref_below_amp: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (iref <= $past(amp_cmd)));
  a_r1_integ_idle: assert property (@(posedge clk)
    !rst_n |=> (integ_q == '0));
endmodule

// File: tb/dclink_sched_pi_tb.sv
module dclink_sched_pi_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [15:0] vdc_meas = '0, vdc_ref = '0, vac_mag = '0;
  logic [15:0] band_lo = '0, band_hi = '0, band_inv = '0;
  logic [15:0] kp_lo = '0, ki_lo = '0, kp_hi = '0, ki_hi = '0;
  logic signed [31:0] int_min = '0, int_max = '0;
  logic [15:0] amp_cmd, iref;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  longint m_acc = 0;
  longint m_amp = 0;

  always #2.5 clk = ~clk;

  dclink_sched_pi u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .vdc_meas(vdc_meas), .vdc_ref(vdc_ref),
    .vac_mag(vac_mag), .band_lo(band_lo), .band_hi(band_hi), .band_inv(band_inv),
    .kp_lo(kp_lo), .ki_lo(ki_lo), .kp_hi(kp_hi), .ki_hi(ki_hi),
    .int_min(int_min), .int_max(int_max), .amp_cmd(amp_cmd), .iref(iref)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Bench model built from the requirement text
  function automatic longint wgt(input longint mag);
    longint t;
    if (mag <= longint'(band_lo)) return 0;
    if (mag >= longint'(band_hi)) return 32768;
    t = (mag - longint'(band_lo)) * longint'(band_inv);
    return (t > 32768) ? 32768 : t;
  endfunction

  function automatic longint mixg(input longint a, input longint b, input longint w);
    return (a * (32768 - w) + b * w) / 32768;
  endfunction

  task automatic model_step();
    longint e, mag, w, kp, ki, s, o;
    e   = longint'(vdc_ref) - longint'(vdc_meas);
    mag = (e < 0) ? -e : e;
    w   = wgt(mag);
    kp  = mixg(kp_lo, kp_hi, w);
    ki  = mixg(ki_lo, ki_hi, w);
    s   = m_acc + ki * e;
    if (s > longint'(int_max)) s = int_max;
    if (s < longint'(int_min)) s = int_min;
    m_acc = s;
    o = (kp * e + m_acc);
    o = (o >= 0) ? (o / 256) : -((-o + 255) / 256);
    if (o < 0) o = 0;
    if (o > 65535) o = 65535;
    m_amp = o;
  endtask

  // One control update: check amp after the tick edge and iref one cycle later
  task automatic step(input string req, input int ref_v, input int meas_v);
    vdc_ref  = 16'(ref_v);
    vdc_meas = 16'(meas_v);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    model_step();
    chk(req, amp_cmd, m_amp);
    @(negedge clk);
    chk({"R9 ", req}, iref, (m_amp * longint'(vac_mag)) / 65536);
  endtask

  task automatic t_reset();
    chk("R1 amp after reset", amp_cmd, 0);
    chk("R1 iref after reset", iref, 0);
  endtask

  task automatic t_low_band();
    // |e| = 40 <= band_lo: only steady-state gains (R2, R3)
    step("R3 small error", 4050, 4010);
    step("R2 negative small error", 4050, 4080);
  endtask

  task automatic t_mid_band();
    // |e| = 356: weight 16384, halfway blend (R5)
    step("R5 mid band", 4050, 3694);
    step("R5 mid band negative", 4050, 4350);
  endtask

  task automatic t_high_band();
    // |e| = 1050 >= band_hi: transient gains only (R4)
    step("R4 large error", 4050, 3000);
  endtask

  task automatic t_clamps();
    // large positive error saturates the command (R7)
    step("R7 upper clamp", 40000, 0);
    chk("R7 upper clamp value", amp_cmd, 65535);
    // large negative error drives it to zero
    step("R7 lower clamp", 4050, 9000);
    step("R7 lower clamp again", 4050, 9000);
    chk("R7 zero value", amp_cmd, 0);
  endtask

  task automatic t_integ_sat();
    longint first;
    int_max = 50000;
    int_min = -50000;
    step("R6 saturating up", 4050, 3000);
    first = m_amp;
    step("R6 held at max", 4050, 3000);
    chk("R6 amp stays with acc at limit", amp_cmd, first);
    step("R6 saturating down", 4050, 5000);
    step("R6 held at min", 4050, 5000);
    step("R6 recover small", 4050, 4000);
    int_max = 3000000;
    int_min = -2000000;
  endtask

  task automatic t_no_tick();
    longint held;
    step("R8 setup", 4050, 3900);
    held = amp_cmd;
    vdc_meas = 16'd100;
    repeat (4) @(negedge clk);
    chk("R8 amp held without tick", amp_cmd, held);
  endtask

  task automatic t_vac_track();
    vac_mag = 16'd12345;
    @(negedge clk);
    chk("R9 iref follows mains", iref, (longint'(amp_cmd) * 12345) / 65536);
    vac_mag = 16'd65535;
    @(negedge clk);
    chk("R9 iref full mains", iref, (longint'(amp_cmd) * 65535) / 65536);
    vac_mag = 16'd40000;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    band_lo = 16'd100; band_hi = 16'd612; band_inv = 16'd64;
    kp_lo = 16'd256; ki_lo = 16'd16; kp_hi = 16'd2048; ki_hi = 16'd128;
    int_min = -2000000; int_max = 3000000;
    vac_mag = 16'd40000; vdc_ref = 16'd4050; vdc_meas = 16'd4050;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_low_band();
    t_mid_band();
    t_high_band();
    t_clamps();
    t_integ_sat();
    t_no_tick();
    t_vac_track();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule